// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block turns 32-bit reads from a 32 MB memory window into serial flash read transactions and keeps the most recent 1024 bytes in a single line buffer. A read that falls inside the buffered range is answered from the buffer one cycle after it is accepted. A read outside that range starts a refill. The engine clears the shifter's byte queues and drives the chip select of the addressed flash device. It then streams the read command over a byte-wide handshake, clocks in a whole line of data, releases the chip select and returns the requested word. The new line always starts at the word that missed.

The command is assembled from a configuration register that sits inside the block. The register supplies the opcode, an optional mode byte, a count of dummy bytes, the byte order used to pack received data into words, and a dual-memory setting. When the dual-memory setting is on, the flash address is half the window address. The block does not contain the serial shifter or the flash devices. It talks to the shifter through the transmit/receive byte handshake and the queue-clear strobe.

Top module: `lin_flash_reader`

## Requirements
- R1: Out of reset, `rdReady` is 1, `rdValid` is 0, both chip selects are high (inactive) and `txValid` is 0. The first read after reset always misses.
- R2: A read is accepted when `rdReq` and `rdReady` are both 1. When the word-aligned address A satisfies base <= A <= base + 1020, the read is a hit. `rdValid` is then 1 in exactly the cycle after acceptance, for one cycle, with buffer word (A - base) / 4. No queue clear, chip select or byte traffic occurs.
- R3: Any other accepted read is a miss. `rdReady` stays 0 until the response, and `shiftFlush` pulses exactly once before any byte of the transaction, with the selected chip select already low.
- R4: On a miss, the bytes sent are: the opcode (config bits 7:0), then flash address bits 23:16, 15:8 and 7:0. If config bit 25 is 1, the mode byte (config bits 23:16) follows. Then come N zero bytes, where N is config bits 10:8. Bytes received during this phase are discarded.
- R5: After the command, 1024 zero bytes are sent. The received bytes are packed four at a time into 256 words. When config bit 26 is 0, the first byte of each group lands in bits 7:0. When it is 1, the first byte lands in bits 31:24.
- R6: When a refill ends, the chip select is released before `rdValid` rises, the miss address becomes the new base, and the response carries buffer word 0.
- R7: When config bits 30 and 29 are both 1, the flash address is the window address shifted right by one; otherwise it equals the window address. The device index is flash address bit 24, and `csN[i]` is driven low for device i.
- R8: The configuration register resets to 0x03A002EB and is loaded from `cfgWdata` when `cfgWe` is 1.
- R9: Address bits 1:0 are ignored, for both the hit test and the miss address.
- R10: A miss uses the configuration value as it stood in its accepting cycle. A write in that same cycle, or during the refill, affects only later misses.
- R11: At most one byte is outstanding. After a byte is taken (`txValid` and `txReady` both 1), `txValid` stays 0 until the matching `rxValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReq | input | 1 | Read request |
| rdAddr | input | 25 | Byte address in the window |
| rdReady | output | 1 | Engine can accept a read |
| rdValid | output | 1 | Response word valid (one cycle) |
| rdData | output | 32 | Response word |
| cfgWe | input | 1 | Configuration register write strobe |
| cfgWdata | input | 32 | Configuration register write value |
| shiftFlush | output | 1 | Clear the shifter's byte queues |
| csN | output | 2 | Active-low chip selects, one per flash device |
| txValid | output | 1 | Byte to send is valid |
| txByte | output | 8 | Byte to send |
| txReady | input | 1 | Shifter takes the byte |
| rxValid | input | 1 | Received byte valid |
| rxByte | input | 8 | Received byte |

## Verification
Two events can land in the same cycle: a configuration write and the acceptance of a read that misses. The bench drives `cfgWe` and `rdReq` on the same clock edge. Its model builds the expected command and data packing from the value held before the write. It then expects the following miss to use the newly written opcode, mode byte, dummy count, byte order and dual-memory division. A mismatch shows up either in the captured byte stream or in the returned word.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

  // Configuration field positions (the command layout depends on them).
  localparam int CFG_OPC_LO    = 0;
  localparam int CFG_OPC_HI    = 7;
  localparam int CFG_DUMMY_LO  = 8;
  localparam int CFG_DUMMY_HI  = 10;
  localparam int CFG_MODE_LO   = 16;
  localparam int CFG_MODE_HI   = 23;
  localparam int CFG_MODE_EN   = 25;
  localparam int CFG_BIG_END   = 26;
  localparam int CFG_SPLIT_BUS = 29;
  localparam int CFG_DUAL_MEM  = 30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESP,
    ST_FLUSH,
    ST_CMD,
    ST_DATA,
    ST_DONE
  } lfrState_e;

  // Strobes and levels from control to datapath.
  typedef struct packed {
    logic latchReq;   // read accepted: snapshot address and configuration
    logic takeHit;    // accepted read hits: load the response word
    logic flush;      // clear shifter queues
    logic csActive;   // drive the selected chip select
    logic dataPhase;  // sending fill bytes rather than command bytes
    logic rxCmd;      // a command-phase byte came back (discarded)
    logic rxData;     // a data-phase byte came back (kept)
    logic commit;     // refill finished: new base, load word 0
  } lfrStrobes_t;

endpackage

// File: rtl/lfr_ctrl.sv
module lfr_ctrl
  import lfr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdReq,
  input  logic        hitNow,
  input  logic        cmdLast,
  input  logic        dataLast,
  input  logic        txReady,
  input  logic        rxValid,
  output logic        rdReady,
  output logic        rdValid,
  output logic        txValid,
  output lfrStrobes_t st
);

  lfrState_e state, stateNxt;
  logic      waitRx;
  logic      accept;
  logic      rxTake;

  assign rdReady = (state == ST_IDLE);
  assign rdValid = (state == ST_RESP);
  assign txValid = ((state == ST_CMD) || (state == ST_DATA)) && !waitRx;
  assign accept  = rdReq && rdReady;
  assign rxTake  = waitRx && rxValid;

  always_comb begin
    st           = '0;
    st.latchReq  = accept;
    st.takeHit   = accept && hitNow;
    st.flush     = (state == ST_FLUSH);
    st.csActive  = (state == ST_FLUSH) || (state == ST_CMD) || (state == ST_DATA);
    st.dataPhase = (state == ST_DATA);
    st.rxCmd     = (state == ST_CMD) && rxTake;
    st.rxData    = (state == ST_DATA) && rxTake;
    st.commit    = (state == ST_DONE);
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNxt = hitNow ? ST_RESP : ST_FLUSH;
      ST_RESP:  stateNxt = ST_IDLE;
      ST_FLUSH: stateNxt = ST_CMD;
      ST_CMD:   if (st.rxCmd && cmdLast) stateNxt = ST_DATA;
      ST_DATA:  if (st.rxData && dataLast) stateNxt = ST_DONE;
      ST_DONE:  stateNxt = ST_RESP;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      waitRx <= 1'b0;
    end else begin
      state <= stateNxt;
      if (txValid && txReady) begin
        waitRx <= 1'b1;
      end else if (rxTake) begin
        waitRx <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lfr_dp.sv
module lfr_dp
  import lfr_pkg::*;
#(
  parameter int          ADDR_W     = 25,
  parameter int          SLAVE_BIT  = 24,
  parameter int          NUM_SLAVES = 2,
  parameter int          LINE_BYTES = 1024,
  parameter logic [31:0] CFG_RESET  = 32'h03A0_02EB
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lfrStrobes_t           st,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic                  cfgWe,
  input  logic [31:0]           cfgWdata,
  input  logic [7:0]            rxByte,
  output logic                  hitNow,
  output logic                  cmdLast,
  output logic                  dataLast,
  output logic [7:0]            txByte,
  output logic [NUM_SLAVES-1:0] csN,
  output logic [31:0]           rdData
);

  localparam int LINE_WORDS = LINE_BYTES / 4;
  localparam int CNT_W      = $clog2(LINE_BYTES);
  localparam int IDX_W      = CNT_W - 2;
  localparam int SEL_W      = ADDR_W - SLAVE_BIT;

  logic [31:0]       cfgQ, cfgS;
  logic [ADDR_W-1:0] reqAddr, baseQ, alignedAddr, offset, flashAddr;
  logic              baseValid;
  logic [CNT_W-1:0]  cnt, cmdLen;
  logic [23:0]       hold;
  logic [31:0]       fillWord, dataQ;
  logic [SEL_W-1:0]  slaveSel;
  logic [31:0]       lineMem [LINE_WORDS];
  logic              unusedBits;

  // Hit test on the incoming word-aligned address.
  assign alignedAddr = {rdAddr[ADDR_W-1:2], 2'b00};
  assign offset      = alignedAddr - baseQ;
  assign hitNow      = baseValid && (alignedAddr >= baseQ) &&
                       (offset <= ADDR_W'(LINE_BYTES - 4));

  // Flash address and device select from the snapshot.
  assign flashAddr = (cfgS[CFG_DUAL_MEM] && cfgS[CFG_SPLIT_BUS]) ? (reqAddr >> 1) : reqAddr;
  assign slaveSel  = flashAddr[ADDR_W-1:SLAVE_BIT];

  assign cmdLen   = CNT_W'(4) + CNT_W'(cfgS[CFG_MODE_EN]) +
                    CNT_W'(cfgS[CFG_DUMMY_HI:CFG_DUMMY_LO]);
  assign cmdLast  = (cnt == cmdLen - CNT_W'(1));
  assign dataLast = (cnt == CNT_W'(LINE_BYTES - 1));

  always_comb begin
    txByte = 8'h00;
    if (!st.dataPhase) begin
      case (cnt)
        CNT_W'(0): txByte = cfgS[CFG_OPC_HI:CFG_OPC_LO];
        CNT_W'(1): txByte = flashAddr[23:16];
        CNT_W'(2): txByte = flashAddr[15:8];
        CNT_W'(3): txByte = flashAddr[7:0];
        CNT_W'(4): txByte = cfgS[CFG_MODE_EN] ? cfgS[CFG_MODE_HI:CFG_MODE_LO] : 8'h00;
        default:   txByte = 8'h00;
      endcase
    end
  end

  // hold[23:16] is the oldest byte of the current group.
  assign fillWord = cfgS[CFG_BIG_END] ? {hold, rxByte}
                                      : {rxByte, hold[7:0], hold[15:8], hold[23:16]};

  for (genvar g = 0; g < NUM_SLAVES; g++) begin : g_cs
    assign csN[g] = !(st.csActive && (slaveSel == SEL_W'(g)));
  end

  assign rdData = dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= CFG_RESET;
    end else if (cfgWe) begin
      cfgQ <= cfgWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgS    <= CFG_RESET;
      reqAddr <= '0;
    end else if (st.latchReq) begin
      cfgS    <= cfgQ;
      reqAddr <= alignedAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      hold <= '0;
    end else if (st.latchReq) begin
      cnt <= '0;
    end else if (st.rxCmd) begin
      cnt <= cmdLast ? '0 : cnt + CNT_W'(1);
    end else if (st.rxData) begin
      cnt  <= cnt + CNT_W'(1);
      hold <= {hold[15:0], rxByte};
    end
  end

  always_ff @(posedge clk) begin
    if (st.rxData && (cnt[1:0] == 2'b11)) begin
      lineMem[cnt[CNT_W-1:2]] <= fillWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ     <= '0;
      baseValid <= 1'b0;
      dataQ     <= '0;
    end else begin
      if (st.takeHit) begin
        dataQ <= lineMem[offset[CNT_W-1:2]];
      end
      if (st.commit) begin
        baseQ     <= reqAddr;
        baseValid <= 1'b1;
        dataQ     <= lineMem[IDX_W'(0)];
      end
    end
  end

  assign unusedBits = ^{rdAddr[1:0], cfgS[31], cfgS[28:27], cfgS[24], cfgS[15:11]};

endmodule

// File: rtl/lin_flash_reader.sv
module lin_flash_reader
  import lfr_pkg::*;
#(
  parameter int          ADDR_W     = 25,
  parameter int          SLAVE_BIT  = 24,
  parameter int          NUM_SLAVES = 2,
  parameter int          LINE_BYTES = 1024,
  parameter logic [31:0] CFG_RESET  = 32'h03A0_02EB
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rdReq,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic                  rdReady,
  output logic                  rdValid,
  output logic [31:0]           rdData,
  input  logic                  cfgWe,
  input  logic [31:0]           cfgWdata,
  output logic                  shiftFlush,
  output logic [NUM_SLAVES-1:0] csN,
  output logic                  txValid,
  output logic [7:0]            txByte,
  input  logic                  txReady,
  input  logic                  rxValid,
  input  logic [7:0]            rxByte
);

  lfrStrobes_t st;
  logic        hitNow, cmdLast, dataLast;

  lfr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdReq    (rdReq),
    .hitNow   (hitNow),
    .cmdLast  (cmdLast),
    .dataLast (dataLast),
    .txReady  (txReady),
    .rxValid  (rxValid),
    .rdReady  (rdReady),
    .rdValid  (rdValid),
    .txValid  (txValid),
    .st       (st)
  );

  lfr_dp #(
    .ADDR_W     (ADDR_W),
    .SLAVE_BIT  (SLAVE_BIT),
    .NUM_SLAVES (NUM_SLAVES),
    .LINE_BYTES (LINE_BYTES),
    .CFG_RESET  (CFG_RESET)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .rdAddr   (rdAddr),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .rxByte   (rxByte),
    .hitNow   (hitNow),
    .cmdLast  (cmdLast),
    .dataLast (dataLast),
    .txByte   (txByte),
    .csN      (csN),
    .rdData   (rdData)
  );

  assign shiftFlush = st.flush;

endmodule

// File: rtl/lfr_checker.sv
module lfr_checker #(
  parameter int NUM_SLAVES = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  rdReq,
  input logic                  rdReady,
  input logic                  rdValid,
  input logic                  shiftFlush,
  input logic [NUM_SLAVES-1:0] csN,
  input logic                  txValid,
  input logic                  txReady
);

  // R1: no byte traffic while the engine is idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |-> !txValid);

  // R2: response is a single-cycle pulse
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R3: an accepted read always takes the engine out of idle
  p_accept_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdReady) |=> !rdReady);

  // R3: queue clear happens with a chip select already driven
  p_flush_cs_r3: assert property (@(posedge clk) disable iff (!rstN)
    shiftFlush |-> !(&csN));

  // R6: chip selects are released whenever a response is presented
  p_cs_released_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (&csN));

  // R7: never more than one device selected
  p_one_cs_r7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1);

  // R11: one byte outstanding at a time
  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txValid);

endmodule

bind lin_flash_reader lfr_checker #(.NUM_SLAVES(NUM_SLAVES)) u_lfr_checker (
  .clk        (clk),
  .rstN       (rstN),
  .rdReq      (rdReq),
  .rdReady    (rdReady),
  .rdValid    (rdValid),
  .shiftFlush (shiftFlush),
  .csN        (csN),
  .txValid    (txValid),
  .txReady    (txReady)
);

// File: tb/lin_flash_reader_bench.sv
module lin_flash_reader_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rdReq;
  logic [24:0] rdAddr;
  logic        rdReady, rdValid;
  logic [31:0] rdData;
  logic        cfgWe;
  logic [31:0] cfgWdata;
  logic        shiftFlush;
  logic [1:0]  csN;
  logic        txValid;
  logic [7:0]  txByte;
  logic        txReady;
  logic        rxValid;
  logic [7:0]  rxByte;

  always #4 clk = ~clk;

  lin_flash_reader u_lin_flash_reader (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdReady(rdReady), .rdValid(rdValid), .rdData(rdData),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .shiftFlush(shiftFlush),
    .csN(csN), .txValid(txValid), .txByte(txByte), .txReady(txReady),
    .rxValid(rxValid), .rxByte(rxByte)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // Reference model state
  logic [31:0] mCfg;
  logic [24:0] mBase;
  bit          mValid;
  logic [31:0] mLine [256];

  // Shifter / flash model state
  logic [7:0]  txq[$];
  int          flushCnt, tcount, csErr, ovErr, pendCnt, curSlave, curCmdLen;
  bit          csSeen;
  logic [23:0] curFa;
  logic [7:0]  rxNext;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] flashByte(input int slave, input logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ ((slave != 0) ? 8'h5A : 8'hC3);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog cycles=%0d expected<=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Shifter and flash model, driven and sampled away from the active edge
  always @(negedge clk) begin
    logic [1:0] expCs;
    if (rstN) begin
      if (rxValid) rxValid = 1'b0;
      if (pendCnt > 0) begin
        pendCnt--;
        if (pendCnt == 0) begin
          rxValid = 1'b1;
          rxByte  = rxNext;
        end
      end
      if ((pendCnt > 0 || rxValid) && txValid) ovErr++;
      txReady = (pendCnt == 0) && !rxValid && (cyc % 3 != 2);
      if (shiftFlush) begin
        flushCnt++;
        tcount = 0;
        txq.delete();
      end
      if (csN != 2'b11) begin
        csSeen = 1'b1;
        expCs  = ~(2'(1) << curSlave);
        if (csN != expCs) csErr++;
      end
      if (txValid && txReady) begin
        txq.push_back(txByte);
        rxNext = (tcount < curCmdLen) ? 8'hEE
                 : flashByte(curSlave, curFa + 24'(tcount - curCmdLen));
        tcount++;
        pendCnt = 1 + (cyc % 2);
      end
    end
  end

  task automatic doRead(input logic [24:0] addr, input bit withCfg,
                        input logic [31:0] newCfg, input string tag);
    logic [24:0] al;
    logic [24:0] fa25;
    logic [31:0] c;
    logic [31:0] expWord;
    logic [7:0]  b0, b1, b2, b3;
    logic [7:0]  expq[$];
    bit          hit;
    int          lat, mism;
    al  = {addr[24:2], 2'b00};
    hit = mValid && (al >= mBase) && ((al - mBase) <= 25'd1020);
    flushCnt = 0; csErr = 0; csSeen = 1'b0;
    txq.delete();
    if (!hit) begin
      c    = mCfg;
      fa25 = (c[30] && c[29]) ? (al >> 1) : al;
      curSlave  = int'(fa25[24]);
      curFa     = fa25[23:0];
      curCmdLen = 4 + int'(c[25]) + int'(c[10:8]);
      expq.push_back(c[7:0]);
      expq.push_back(curFa[23:16]);
      expq.push_back(curFa[15:8]);
      expq.push_back(curFa[7:0]);
      if (c[25]) expq.push_back(c[23:16]);
      for (int k = 0; k < int'(c[10:8]); k++) expq.push_back(8'h00);
      for (int k = 0; k < 1024; k++) expq.push_back(8'h00);
      for (int i = 0; i < 256; i++) begin
        b0 = flashByte(curSlave, curFa + 24'(4 * i));
        b1 = flashByte(curSlave, curFa + 24'(4 * i + 1));
        b2 = flashByte(curSlave, curFa + 24'(4 * i + 2));
        b3 = flashByte(curSlave, curFa + 24'(4 * i + 3));
        mLine[i] = c[26] ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
      end
      expWord = mLine[0];
    end else begin
      expWord = mLine[(al - mBase) >> 2];
    end
    while (!rdReady) @(negedge clk);
    rdReq  = 1'b1;
    rdAddr = addr;
    if (withCfg) begin
      cfgWe    = 1'b1;
      cfgWdata = newCfg;
    end
    @(negedge clk);
    rdReq = 1'b0;
    cfgWe = 1'b0;
    if (withCfg) mCfg = newCfg;
    if (hit) begin
      chk(rdValid === 1'b1 && rdReady === 1'b0, {tag, " R2 hit response next cycle"},
          {rdValid, rdReady}, 2'b10);
      chk(rdData === expWord, {tag, " R2 hit data"}, rdData, expWord);
      chk(txq.size() == 0 && flushCnt == 0 && !csSeen, {tag, " R2 hit has no flash traffic"},
          txq.size() + flushCnt, 0);
    end else begin
      chk(rdValid === 1'b0 && rdReady === 1'b0, {tag, " R3 miss stalls"},
          {rdValid, rdReady}, 2'b00);
      lat = 1;
      while (!rdValid && lat < 20000) begin
        @(negedge clk);
        lat++;
      end
      chk(rdValid === 1'b1, {tag, " R6 refill response arrives"}, rdValid, 1);
      chk(rdData === expWord, {tag, " R5 R6 refill word"}, rdData, expWord);
      chk(csN === 2'b11, {tag, " R6 chip select released"}, csN, 2'b11);
      chk(flushCnt == 1, {tag, " R3 one queue clear"}, flushCnt, 1);
      chk(csSeen && csErr == 0, {tag, " R7 device select"}, csErr, 0);
      chk(txq.size() == expq.size(), {tag, " R4 R5 byte count"}, txq.size(), expq.size());
      mism = 0;
      for (int k = 0; k < expq.size() && k < txq.size(); k++)
        if (txq[k] !== expq[k]) mism++;
      chk(mism == 0, {tag, " R4 R5 byte stream"}, mism, 0);
      mValid = 1'b1;
      mBase  = al;
    end
    @(negedge clk);
    chk(rdValid === 1'b0, {tag, " R2 response is one cycle"}, rdValid, 0);
  endtask

  initial begin
    rstN = 1'b0; rdReq = 1'b0; rdAddr = '0; cfgWe = 1'b0; cfgWdata = '0;
    txReady = 1'b0; rxValid = 1'b0; rxByte = '0;
    pendCnt = 0; curSlave = 0; curFa = '0; curCmdLen = 0; tcount = 0; ovErr = 0;
    mCfg = 32'h03A0_02EB; mValid = 1'b0; mBase = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(rdReady === 1'b1 && rdValid === 1'b0, "R1 reset handshake", {rdReady, rdValid}, 2'b10);
    chk(csN === 2'b11 && txValid === 1'b0, "R1 reset selects and traffic", {csN, txValid}, 3'b110);

    doRead(25'h000100, 1'b0, '0, "R1 R8 first read");
    doRead(25'h000104, 1'b0, '0, "R2 mid line");
    doRead(25'h0004FC, 1'b0, '0, "R2 last word");
    doRead(25'h000500, 1'b0, '0, "R3 past line");
    doRead(25'h0004F8, 1'b0, '0, "R3 below base");
    doRead(25'h1000010, 1'b0, '0, "R7 upper device");
    // Big-endian packing, mode byte off, five dummy bytes, opcode 6B
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = 32'h0400_056B;
    @(negedge clk);
    cfgWe = 1'b0; mCfg = 32'h0400_056B;
    doRead(25'h000200, 1'b0, '0, "R5 R8 big endian");
    doRead(25'h000207, 1'b0, '0, "R9 low bits");
    // Same-cycle config write and miss: old value governs this refill
    doRead(25'h000800, 1'b1, 32'h625F_003B, "R10 same cycle");
    doRead(25'h1000020, 1'b0, '0, "R7 R10 dual memory");
    doRead(25'h1000024, 1'b0, '0, "R2 dual hit");
    chk(ovErr == 0, "R11 one byte outstanding", ovErr, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule